// File: doc/BRIEF.md
# Multicast Hash Destination Filter

This block sits at the head of an Ethernet receive path and decides, from the six destination address bytes of a frame, whether the frame is accepted. The bytes arrive one per valid cycle, and a start-of-frame flag marks the first of them. A frame is accepted when any of these holds:
- its address equals the configured station address;
- it is the all-ones broadcast address;
- it is a group address whose hash selects a set bit in a 64-bit filter vector;
- promiscuous mode is on.

The hash is a reflected CRC-32 over the six address bytes. Its six most significant bits pick one filter bit.

A small controller has three states:
- `S_WAIT_SOF`: waits for a byte flagged as start of frame.
- `S_COLLECT`: takes the remaining address bytes.
- `S_DECIDE`: presents the decision for exactly one cycle.

The transitions are:
- `WAIT_SOF→COLLECT` on a start byte.
- `COLLECT→DECIDE` on the sixth byte.
- `DECIDE→WAIT_SOF` when no new frame starts.
- `DECIDE→COLLECT` when a start byte arrives in that cycle.
- `COLLECT→COLLECT` on a start byte. This restarts the count: it aborts the frame in progress and begins a new one.

Payload bytes that follow the address are ignored until the next start-of-frame. Configuration inputs are static while a frame is in flight and are read in the decision cycle.

Top module: `mcast_dest_filter`

## Requirements
- R1: After reset `decide_vld_o` and `accept_o` are 0.
- R2: `decide_vld_o` is a single-cycle pulse in the cycle after the sixth address byte is taken. Idle cycles between bytes stall the count. `accept_o` is 0 whenever `decide_vld_o` is 0.
- R3: An address equal to `station_addr_i` is accepted. Bits [7:0] of `station_addr_i` hold the first byte on the wire, and bits [47:40] hold the sixth.
- R4: When `cfg_mode_i[3]` is 1, a station address match alone does not accept the frame.
- R5: The all-ones address is accepted unless `cfg_mode_i[2]` is 1. When that bit is 1, the all-ones address is rejected, unless another rule accepts it.
- R6: When `cfg_mode_i[7]` is 1, every frame is accepted.
- R7: The hash index is computed as follows:
  - A CRC is seeded with 0xFFFFFFFF.
  - It is advanced bit by bit, least significant bit of each byte first, with the reflected polynomial 0xEDB88320.
  - No final inversion is applied.
  - The index is bits [31:26] of the result. Index bits [5:3] select the filter byte and bits [2:0] select the bit in that byte, so the index equals the bit number in `hash_table_i`.
  - A group address that is not broadcast is accepted when that bit is 1.
- R8: Only addresses with bit 0 of the first byte set consult the filter. A non-matching individual address is rejected even with an all-ones filter.
- R9: A filter of all ones accepts every non-broadcast group address.
- R10: A start-of-frame byte arriving mid-address aborts the old address and begins a new one. Bytes after the sixth produce no decision until the next start-of-frame.
- R11: Bits 6:4 and 1:0 of `cfg_mode_i` have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Marks the current byte as first of a frame |
| byte_vld_i | input | 1 | A byte is present on byte_i |
| byte_i | input | 8 | Destination address byte |
| station_addr_i | input | 48 | Station address, first wire byte in [7:0] |
| hash_table_i | input | 64 | Multicast filter, bit n selected by hash index n |
| cfg_mode_i | input | 8 | Bit 7 promiscuous, bit 3 no station match, bit 2 no broadcast |
| decide_vld_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted, valid with decide_vld_o |

## Verification
The bench recomputes the CRC bit by bit to predict which filter bit each group address selects.

A filter holding only the predicted bit should accept the address. The inverted filter should reject it. A design with a byte-reversed CRC, a complemented result or the wrong index bits fails one of those two checks.

Broadcast is run with the broadcast-disable bit set and an all-ones filter. A design that lets broadcast through the hash path accepts it there.

A start byte in the middle of an address is followed by a full new address. A design that does not restart the count decides too early or against the wrong bytes.

Long payload runs after an address check that the design makes no second decision.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int HASH_BITS  = 6;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // mode bit positions
    localparam int MODE_PROMISC  = 7;
    localparam int MODE_NO_PHYS  = 3;
    localparam int MODE_NO_BCAST = 2;

    typedef enum logic [1:0] {
        S_WAIT_SOF = 2'd0,
        S_COLLECT  = 2'd1,
        S_DECIDE   = 2'd2
    } dfilt_state_e;

    // one byte of a reflected CRC, LSB of the byte first
    function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                            input logic [7:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dfilt_ctrl.sv
module dfilt_ctrl
    import dfilt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    localparam int IDX_W = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             byte_vld_i,
    output logic             take_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic             decide_o
);

    dfilt_state_e     state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;
    logic             start;
    logic             last;

    assign start      = byte_vld_i & sof_i;
    assign take_o     = start | (byte_vld_i & (state_q == S_COLLECT));
    assign byte_idx_o = start ? '0 : cnt_q;
    assign last       = take_o & (byte_idx_o == IDX_W'(NBYTES - 1));

    always_comb begin
        state_d = state_q;
        cnt_d   = take_o ? byte_idx_o + IDX_W'(1) : cnt_q;
        if (start) begin
            state_d = last ? S_DECIDE : S_COLLECT;
        end else begin
            unique case (state_q)
                S_WAIT_SOF: state_d = S_WAIT_SOF;
                S_COLLECT:  state_d = last ? S_DECIDE : S_COLLECT;
                S_DECIDE:   state_d = S_WAIT_SOF;
                default:    state_d = S_WAIT_SOF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT_SOF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        decide_o = (state_q == S_DECIDE);
    end

endmodule

// File: rtl/dfilt_crc.sv
module dfilt_crc
    import dfilt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    parameter int HBITS  = HASH_BITS,
    localparam int IDX_W = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [IDX_W-1:0] byte_idx_i,
    input  logic [7:0]       byte_i,
    output logic [HBITS-1:0] hash_o
);

    logic [31:0] crc_q;
    logic [31:0] base;

    assign base = (byte_idx_i == '0) ? CRC_SEED : crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (take_i) crc_q <= crc_step(base, byte_i);
    end

    assign hash_o = crc_q[31 -: HBITS];

endmodule

// File: rtl/dfilt_cmp.sv
module dfilt_cmp
    import dfilt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    localparam int IDX_W = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  byte_idx_i,
    input  logic [7:0]        byte_i,
    input  logic [8*NBYTES-1:0] station_i,
    output logic              phys_eq_o,
    output logic              bcast_o,
    output logic              group_o
);

    logic [7:0] sa_byte;
    logic       first;
    logic       phys_q, bc_q, grp_q;

    always_comb begin
        sa_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (byte_idx_i == IDX_W'(i)) sa_byte = station_i[8*i +: 8];
        end
    end

    assign first = (byte_idx_i == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q <= 1'b0;
            bc_q   <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take_i) begin
            phys_q <= (byte_i == sa_byte) & (first | phys_q);
            bc_q   <= (&byte_i) & (first | bc_q);
            if (first) grp_q <= byte_i[0];
        end
    end

    assign phys_eq_o = phys_q;
    assign bcast_o   = bc_q;
    assign group_o   = grp_q;

endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide
    import dfilt_pkg::*;
#(
    parameter int HBITS = HASH_BITS,
    localparam int TBL  = 1 << HBITS
) (
    input  logic             decide_i,
    input  logic             phys_eq_i,
    input  logic             bcast_i,
    input  logic             group_i,
    input  logic [HBITS-1:0] hash_i,
    input  logic [TBL-1:0]   table_i,
    input  logic [7:0]       mode_i,
    output logic             accept_o
);

    logic via_phys, via_bcast, via_hash, any;

    assign via_phys  = phys_eq_i & ~mode_i[MODE_NO_PHYS];
    assign via_bcast = bcast_i & ~mode_i[MODE_NO_BCAST];
    assign via_hash  = group_i & ~bcast_i & table_i[hash_i];
    assign any       = mode_i[MODE_PROMISC] | via_phys | via_bcast | via_hash;
    assign accept_o  = decide_i & any;

endmodule

// File: rtl/mcast_dest_filter.sv
module mcast_dest_filter
    import dfilt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    parameter int HBITS  = HASH_BITS,
    localparam int IDX_W = $clog2(NBYTES + 1),
    localparam int TBL   = 1 << HBITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                byte_vld_i,
    input  logic [7:0]          byte_i,
    input  logic [8*NBYTES-1:0] station_addr_i,
    input  logic [TBL-1:0]      hash_table_i,
    input  logic [7:0]          cfg_mode_i,
    output logic                decide_vld_o,
    output logic                accept_o
);

    logic             take;
    logic [IDX_W-1:0] byte_idx;
    logic             decide;
    logic [HBITS-1:0] hash;
    logic             phys_eq, bcast, group;

    dfilt_ctrl #(.NBYTES(NBYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .byte_vld_i (byte_vld_i),
        .take_o     (take),
        .byte_idx_o (byte_idx),
        .decide_o   (decide)
    );

    dfilt_crc #(.NBYTES(NBYTES), .HBITS(HBITS)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .byte_idx_i (byte_idx),
        .byte_i     (byte_i),
        .hash_o     (hash)
    );

    dfilt_cmp #(.NBYTES(NBYTES)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .byte_idx_i (byte_idx),
        .byte_i     (byte_i),
        .station_i  (station_addr_i),
        .phys_eq_o  (phys_eq),
        .bcast_o    (bcast),
        .group_o    (group)
    );

    dfilt_decide #(.HBITS(HBITS)) u_dec (
        .decide_i  (decide),
        .phys_eq_i (phys_eq),
        .bcast_i   (bcast),
        .group_i   (group),
        .hash_i    (hash),
        .table_i   (hash_table_i),
        .mode_i    (cfg_mode_i),
        .accept_o  (accept_o)
    );

    assign decide_vld_o = decide;

endmodule

// File: rtl/dfilt_checker.sv
module dfilt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sof_i,
    input logic       byte_vld_i,
    input logic [7:0] cfg_mode_i,
    input logic       decide_vld_o,
    input logic       accept_o
);

    assert_accept_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !decide_vld_o |-> !accept_o);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decide_vld_o |=> !decide_vld_o);

    assert_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decide_vld_o |-> $past(byte_vld_i));

    assert_promisc_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_vld_o && cfg_mode_i[7]) |-> accept_o);

    assert_restart_no_decide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && byte_vld_i) |=> !decide_vld_o);

endmodule

bind mcast_dest_filter dfilt_checker u_dfilt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_i        (sof_i),
    .byte_vld_i   (byte_vld_i),
    .cfg_mode_i   (cfg_mode_i),
    .decide_vld_o (decide_vld_o),
    .accept_o     (accept_o)
);

// File: tb/mcast_dest_filter_test.sv
module mcast_dest_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [47:0] sa = 48'h5634_1200_AA02;
    logic [63:0] tbl = '0;
    logic [7:0]  mode = '0;
    logic        decide_vld_o, accept_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    mcast_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .station_addr_i(sa), .hash_table_i(tbl),
        .cfg_mode_i(mode), .decide_vld_o(decide_vld_o), .accept_o(accept_o)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] r;
        r = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            logic fb;
            fb = r[0] ^ a[n];
            r  = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB8_8320;
        end
        return r[31:26];
    endfunction

    function automatic logic expect_acc(input logic [47:0] a, input logic [7:0] m,
                                        input logic [63:0] t, input logic [47:0] s);
        logic r;
        r = m[7];
        if (a == s && !m[3]) r = 1'b1;
        if (a == BCAST && !m[2]) r = 1'b1;
        if (a[0] && a != BCAST && t[hidx(a)]) r = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive six bytes (with optional idle gaps) and return the decision
    task automatic send(input logic [47:0] a, input bit gaps,
                        output logic v, output logic acc);
        for (int i = 0; i < 6; i++) begin
            if (gaps && i > 0) begin
                int g;
                g = $urandom_range(0, 2);
                repeat (g) begin
                    @(negedge clk);
                    byte_vld_i = 1'b0; sof_i = 1'b0;
                end
            end
            @(negedge clk);
            byte_vld_i = 1'b1;
            sof_i      = (i == 0);
            byte_i     = a[8*i +: 8];
        end
        @(negedge clk);
        byte_vld_i = 1'b0; sof_i = 1'b0;
        v   = decide_vld_o;
        acc = accept_o;
    endtask

    task automatic frame(input string req, input logic [47:0] a, input bit gaps);
        logic v, acc;
        send(a, gaps, v, acc);
        chk({req, " valid"}, {31'd0, v}, 32'd1);
        chk(req, {31'd0, acc}, {31'd0, expect_acc(a, mode, tbl, sa)});
    endtask

    initial begin
        logic [47:0] mc;
        logic [5:0]  ix;
        logic        v, acc;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 decide", {31'd0, decide_vld_o}, 32'd0);
        chk("R1 accept", {31'd0, accept_o}, 32'd0);
        rst_n = 1'b1;

        // R3 station match, R4 disabled
        mode = 8'h00; frame("R3 phys", sa, 1'b0);
        mode = 8'h08; send(sa, 1'b0, v, acc);
        chk("R4 phys disabled", {31'd0, acc}, 32'd0);

        // R5 broadcast and its disable with an all-ones filter
        mode = 8'h00; tbl = '0; frame("R5 bcast", BCAST, 1'b0);
        mode = 8'h04; tbl = '1; send(BCAST, 1'b0, v, acc);
        chk("R5 bcast disabled", {31'd0, acc}, 32'd0);

        // R6 promiscuous
        mode = 8'h8C; tbl = '0; send(48'h1111_2222_3344, 1'b1, v, acc);
        chk("R6 promisc", {31'd0, acc}, 32'd1);

        // R7 single hash bit hit and miss
        mode = 8'h00;
        mc = 48'h0100_005E_0001 | 48'h1;
        ix = hidx(mc);
        tbl = 64'd1 << ix;
        send(mc, 1'b0, v, acc);
        chk("R7 hash hit", {31'd0, acc}, 32'd1);
        tbl = ~(64'd1 << ix);
        send(mc, 1'b0, v, acc);
        chk("R7 hash miss", {31'd0, acc}, 32'd0);

        // R8 unicast with full filter rejected
        tbl = '1;
        send(48'h0A0B_0C0D_0E02, 1'b0, v, acc);
        chk("R8 unicast not hashed", {31'd0, acc}, 32'd0);

        // R9 all-ones filter accepts group addresses
        for (int k = 0; k < 6; k++) begin
            mc = {$urandom(), $urandom()} ;
            mc[0] = 1'b1;
            send(mc, 1'b1, v, acc);
            chk("R9 all multicast", {31'd0, acc}, 32'd1);
        end

        // R10 abort mid-address then a full new address
        tbl = '0; mode = 8'h00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld_i = 1'b1; sof_i = (i == 0); byte_i = sa[8*i +: 8];
        end
        frame("R10 abort", 48'h9988_7766_5544, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld_i = 1'b1; sof_i = (i == 0); byte_i = 8'h12;
        end
        frame("R10 abort to station", sa, 1'b0);

        // R10 payload after address produces no decision
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                seen += decide_vld_o;
                byte_vld_i = 1'b1; sof_i = 1'b0; byte_i = sa[7:0];
            end
            @(negedge clk);
            seen += decide_vld_o;
            byte_vld_i = 1'b0;
            @(negedge clk);
            seen += decide_vld_o;
            chk("R10 payload ignored", seen, 0);
            chk("R2 accept low idle", {31'd0, accept_o}, 32'd0);
        end

        // R11 spare mode bits
        mode = 8'h73; send(sa, 1'b0, v, acc);
        chk("R11 spare bits", {31'd0, acc}, 32'd1);
        mode = 8'h73; send(48'h0000_0000_0302, 1'b0, v, acc);
        chk("R11 spare bits reject", {31'd0, acc}, 32'd0);

        // constrained random, R2 R3 R5 R7 with gaps
        for (int k = 0; k < 80; k++) begin
            logic [47:0] a;
            int sel;
            sel  = $urandom_range(0, 4);
            mode = 8'($urandom) & 8'h8C;
            if ($urandom_range(0, 3) != 0) mode[7] = 1'b0;
            tbl  = {$urandom(), $urandom()};
            a    = {$urandom(), $urandom()};
            if (sel == 0) a = sa;
            if (sel == 1) a = BCAST;
            if (sel == 2) a[0] = 1'b1;
            frame("R2 R3 R5 R7 random", a, 1'b1);
        end

        finish_run();
    end

endmodule